// File: doc/BRIEF.md
# Half-Duplex Configurable UART

This block is an asynchronous serial transceiver with one outgoing and one incoming line that share a single direction setting, so at any moment only one of the two halves works. A host writes a character to send, or reads a received character together with its error status. The character length, the parity mode, the number of stop bits and the electrical sense of the line are all set through static configuration inputs.

Bit timing comes from an internal divider. It produces a tick at sixteen times the bit rate. Because only one half is ever active, a single divider serves both halves and is restarted at the moment a transmission is accepted or an incoming start edge is seen. The receiver synchronises the incoming line and confirms the start bit at half a bit time. It then samples every later bit at its centre and hands the character over when it samples the first stop bit.

Top module: `uart_hd_core`

## Requirements
- R1: The transmitter accepts `tx_wr` only while `cfg_dir` is 1 and `tx_busy` is 0, and ignores it otherwise. The receiver works only while `cfg_dir` is 0 and no frame is being sent. A frame on `rx_line` while `cfg_dir` is 1 leaves `rx_valid` at 0.
- R2: One bit lasts exactly 16*(`cfg_div`+1) clock cycles. `tx_line` shows the start bit from the first rising edge after the edge that accepts `tx_wr`.
- R3: A transmitted frame is a start bit at the active level, the data bits with the least significant first, then the parity bit if enabled, then the stop bits at the idle level, and after that the idle level again.
- R4: `cfg_len` values 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits. Received data bits above the selected length read as 0.
- R5: With `cfg_par_en` set, the parity bit makes the number of ones in data plus parity even when `cfg_par_odd` is 0 and odd when it is 1.
- R6: `cfg_two_stop` selects two stop bits instead of one. `tx_busy` stays high for exactly the frame's bit count times the bit period.
- R7: With `cfg_invert` at 0 the line idles high and the start bit is low. With `cfg_invert` at 1 every level on both lines is inverted.
- R8: The receiver ignores a low pulse shorter than half a bit. It confirms a start bit at half a bit time and samples each later bit at its centre.
- R9: `err_parity` is set at frame completion when parity is enabled and the received parity bit does not match. It is 0 when parity is disabled.
- R10: `err_frame` is set at frame completion when the first stop bit is sampled at the active level. The data are still delivered.
- R11: `err_overrun` is set at frame completion when `rx_valid` is still set and `rx_rd` is not asserted in that same cycle. The flag keeps its value until the next completion.
- R12: `rx_valid` rises at frame completion and falls on the cycle after `rx_rd`. A read in the completion cycle leaves `rx_valid` set for the new character.
- R13: After reset `tx_line` sits at the idle level, and `tx_busy`, `rx_valid` and all error flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_div | input | DIV_W | Oversample tick every cfg_div+1 cycles |
| cfg_len | input | 2 | Data length code, 5 + value bits |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | Odd parity when 1, even when 0 |
| cfg_two_stop | input | 1 | Two stop bits when 1 |
| cfg_invert | input | 1 | Inverts both line levels |
| cfg_dir | input | 1 | 1 = transmit, 0 = receive |
| tx_wr | input | 1 | Request to send tx_data |
| tx_data | input | DATA_W | Character to send |
| tx_busy | output | 1 | Frame being sent |
| tx_line | output | 1 | Serial output |
| rx_line | input | 1 | Serial input |
| rx_rd | input | 1 | Host read strobe |
| rx_data | output | DATA_W | Last received character |
| rx_valid | output | 1 | Unread character present |
| err_parity | output | 1 | Parity mismatch in last frame |
| err_frame | output | 1 | Bad first stop bit in last frame |
| err_overrun | output | 1 | Last frame overwrote an unread one |

## Verification
The two events that can fall in the same cycle are a host read on `rx_rd` and the completion of a new incoming frame. The outcome decides whether an overrun is reported and whether `rx_valid` stays set. The bench sends an unread character and then a second frame. It sweeps a one-cycle read pulse across five edges around the expected completion edge. For each trial it notes the edge at which `rx_data` changed and predicts the result from the order of the two edges: a read on or before completion gives no overrun and leaves the new character valid, and a later read gives an overrun and a cleared `rx_valid`.

// File: rtl/uart_hd_pkg.sv
package uart_hd_pkg;
  localparam int DATA_W  = 8;
  localparam int LEN_MIN = 5;
  localparam int FRAME_W = 1 + DATA_W + 1 + 2;
  localparam int NB_W    = $clog2(DATA_W + 1);
  localparam int IDX_W   = $clog2(DATA_W);

  typedef enum logic [2:0] {
    RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP, RX_WAIT
  } rx_state_t;

  // length code to number of data bits
  function automatic logic [NB_W-1:0] bits_of(input logic [1:0] code);
    return NB_W'(LEN_MIN) + NB_W'(code);
  endfunction

  // parity bit over the low nb data bits
  function automatic logic par_bit(input logic [DATA_W-1:0] d,
                                   input logic [NB_W-1:0] nb,
                                   input logic odd);
    logic [DATA_W-1:0] m;
    for (int i = 0; i < DATA_W; i++) m[i] = (i < int'(nb));
    return odd ^ (^(d & m));
  endfunction
endpackage

// File: rtl/uart_hd_baud.sv
module uart_hd_baud #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div,
  input  logic             restart,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;

  assign tick = (cnt_q >= div);

  always_ff @(posedge clk) begin
    if (rst || restart) cnt_q <= '0;
    else if (tick)      cnt_q <= '0;
    else                cnt_q <= cnt_q + 1'b1;
  end

  // back-to-back ticks only with a divider of zero
  assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (rst)
    (tick && !restart && div != '0) |=> (!tick || div == '0))
    else $error("tick spacing");
endmodule

// File: rtl/uart_hd_tx.sv
module uart_hd_tx
  import uart_hd_pkg::*;
#(
  parameter int OS = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              wr,
  input  logic              dir_tx,
  input  logic [DATA_W-1:0] data,
  input  logic [NB_W-1:0]   nbits,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              two_stop,
  input  logic              invert,
  output logic              line,
  output logic              busy,
  output logic              restart
);
  localparam int TC_W = $clog2(OS);
  localparam int LF_W = $clog2(FRAME_W + 1);

  logic               busy_q, busy_n;
  logic               raw_q, raw_n;
  logic               line_q;
  logic [FRAME_W-1:0] shf_q, shf_n, frame;
  logic [LF_W-1:0]    left_q, left_n, total;
  logic [TC_W-1:0]    tcnt_q, tcnt_n;
  logic               accept;

  assign accept  = wr && dir_tx && !busy_q;
  assign restart = accept;

  // frame image, bit 0 first on the line; unused tail stays at idle
  always_comb begin
    logic p;
    p = par_bit(data, nbits, par_odd);
    frame = '1;
    frame[0] = 1'b0;
    for (int i = 0; i < DATA_W; i++)
      if (i < int'(nbits)) frame[i+1] = data[i];
    for (int k = LEN_MIN; k <= DATA_W; k++)
      if (par_en && int'(nbits) == k) frame[k+1] = p;
    total = LF_W'(2) + LF_W'(nbits) + LF_W'(par_en) + LF_W'(two_stop);
  end

  always_comb begin
    busy_n = busy_q;
    raw_n  = raw_q;
    shf_n  = shf_q;
    left_n = left_q;
    tcnt_n = tcnt_q;
    if (!busy_q) begin
      raw_n = 1'b1;
      if (accept) begin
        busy_n = 1'b1;
        raw_n  = frame[0];
        shf_n  = frame >> 1;
        left_n = total - 1'b1;
        tcnt_n = '0;
      end
    end else if (tick) begin
      if (tcnt_q == TC_W'(OS - 1)) begin
        tcnt_n = '0;
        if (left_q == '0) begin
          busy_n = 1'b0;
          raw_n  = 1'b1;
        end else begin
          raw_n  = shf_q[0];
          shf_n  = shf_q >> 1;
          left_n = left_q - 1'b1;
        end
      end else begin
        tcnt_n = tcnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      raw_q  <= 1'b1;
      line_q <= ~invert;
      shf_q  <= '1;
      left_q <= '0;
      tcnt_q <= '0;
    end else begin
      busy_q <= busy_n;
      raw_q  <= raw_n;
      line_q <= raw_n ^ invert;
      shf_q  <= shf_n;
      left_q <= left_n;
      tcnt_q <= tcnt_n;
    end
  end

  assign line = line_q;
  assign busy = busy_q;

  assert_tx_needs_dir_R1: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_q) |-> $past(dir_tx))
    else $error("send began in receive direction");

  assert_tx_idle_level_R7: assert property (@(posedge clk) disable iff (rst)
    (!busy_q && $past(!busy_q)) |-> (line_q == !$past(invert)))
    else $error("idle level wrong");
endmodule

// File: rtl/uart_hd_rx.sv
module uart_hd_rx
  import uart_hd_pkg::*;
#(
  parameter int OS = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              line_in,
  input  logic              invert,
  input  logic [NB_W-1:0]   nbits,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              tick,
  output logic              restart,
  output logic              done,
  output logic [DATA_W-1:0] word,
  output logic              perr,
  output logic              ferr,
  output logic              active
);
  localparam int TC_W = $clog2(OS);
  localparam int HALF = OS / 2;

  rx_state_t         st;
  logic              s1, s2, r;
  logic [TC_W-1:0]   tcnt;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] shv;
  logic              pbit, done_q, perr_q, ferr_q;
  logic              centre;

  assign r       = s2 ^ invert;
  assign restart = en && (st == RX_IDLE) && !r;
  assign centre  = tick && (tcnt == TC_W'(OS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= ~invert;
      s2 <= ~invert;
    end else begin
      s1 <= line_in;
      s2 <= s1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= RX_IDLE;
      tcnt   <= '0;
      idx    <= '0;
      shv    <= '0;
      pbit   <= 1'b0;
      done_q <= 1'b0;
      perr_q <= 1'b0;
      ferr_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (tick && st != RX_IDLE)
        tcnt <= (tcnt == TC_W'(OS - 1)) ? '0 : tcnt + 1'b1;
      if (!en) begin
        st <= RX_IDLE;
      end else begin
        case (st)
          RX_IDLE: if (!r) begin
            st   <= RX_START;
            tcnt <= '0;
          end
          RX_START: if (tick && tcnt == TC_W'(HALF - 1)) begin
            if (!r) begin
              st   <= RX_DATA;
              tcnt <= '0;
              idx  <= '0;
              shv  <= '0;
            end else begin
              st <= RX_IDLE;
            end
          end
          RX_DATA: if (centre) begin
            shv[idx] <= r;
            if (idx == IDX_W'(nbits - 1'b1)) st <= par_en ? RX_PAR : RX_STOP;
            else idx <= idx + 1'b1;
          end
          RX_PAR: if (centre) begin
            pbit <= r;
            st   <= RX_STOP;
          end
          RX_STOP: if (centre) begin
            done_q <= 1'b1;
            ferr_q <= !r;
            perr_q <= par_en && (pbit != par_bit(shv, nbits, par_odd));
            st     <= r ? RX_IDLE : RX_WAIT;
          end
          RX_WAIT: if (r) st <= RX_IDLE;
          default: st <= RX_IDLE;
        endcase
      end
    end
  end

  assign done   = done_q;
  assign word   = shv;
  assign perr   = perr_q;
  assign ferr   = ferr_q;
  assign active = (st != RX_IDLE);

  assert_rx_off_when_disabled_R1: assert property (@(posedge clk) disable iff (rst)
    !$past(en) |-> (st == RX_IDLE))
    else $error("receiver ran while disabled");

  assert_done_single_R12: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q)
    else $error("completion lasted two cycles");
endmodule

// File: rtl/uart_hd_core.sv
module uart_hd_core
  import uart_hd_pkg::*;
#(
  parameter int DIV_W = 16,
  parameter int OS    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic [1:0]        cfg_len,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  input  logic              cfg_two_stop,
  input  logic              cfg_invert,
  input  logic              cfg_dir,
  input  logic              tx_wr,
  input  logic [DATA_W-1:0] tx_data,
  output logic              tx_busy,
  output logic              tx_line,
  input  logic              rx_line,
  input  logic              rx_rd,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              err_parity,
  output logic              err_frame,
  output logic              err_overrun
);
  logic [NB_W-1:0]   nbits;
  logic              tick, tx_restart, rx_restart;
  logic              busy_w, rx_en, rx_done, rx_perr, rx_ferr, rx_active;
  logic [DATA_W-1:0] rx_word;
  logic [DATA_W-1:0] data_q;
  logic              valid_q, perr_q, ferr_q, ovr_q;

  assign nbits = bits_of(cfg_len);
  assign rx_en = !cfg_dir && !busy_w;

  uart_hd_baud #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rst(rst), .div(cfg_div),
    .restart(tx_restart || rx_restart), .tick(tick)
  );

  uart_hd_tx #(.OS(OS)) u_tx (
    .clk(clk), .rst(rst), .tick(tick), .wr(tx_wr), .dir_tx(cfg_dir),
    .data(tx_data), .nbits(nbits), .par_en(cfg_par_en),
    .par_odd(cfg_par_odd), .two_stop(cfg_two_stop), .invert(cfg_invert),
    .line(tx_line), .busy(busy_w), .restart(tx_restart)
  );

  uart_hd_rx #(.OS(OS)) u_rx (
    .clk(clk), .rst(rst), .en(rx_en), .line_in(rx_line),
    .invert(cfg_invert), .nbits(nbits), .par_en(cfg_par_en),
    .par_odd(cfg_par_odd), .tick(tick), .restart(rx_restart),
    .done(rx_done), .word(rx_word), .perr(rx_perr), .ferr(rx_ferr),
    .active(rx_active)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q  <= '0;
      valid_q <= 1'b0;
      perr_q  <= 1'b0;
      ferr_q  <= 1'b0;
      ovr_q   <= 1'b0;
    end else if (rx_done) begin
      data_q  <= rx_word;
      valid_q <= 1'b1;
      perr_q  <= rx_perr;
      ferr_q  <= rx_ferr;
      ovr_q   <= valid_q && !rx_rd;
    end else if (rx_rd) begin
      valid_q <= 1'b0;
    end
  end

  assign tx_busy     = busy_w;
  assign rx_data     = data_q;
  assign rx_valid    = valid_q;
  assign err_parity  = perr_q;
  assign err_frame   = ferr_q;
  assign err_overrun = ovr_q;

  assert_half_duplex_R1: assert property (@(posedge clk) disable iff (rst)
    busy_w |-> !rx_active)
    else $error("both halves active");

  assert_overrun_cause_R11: assert property (@(posedge clk) disable iff (rst)
    $rose(ovr_q) |-> ($past(valid_q) && !$past(rx_rd)))
    else $error("overrun without unread data");

  assert_parity_off_R9: assert property (@(posedge clk) disable iff (rst)
    ($past(rx_done) && !$past(cfg_par_en)) |-> !perr_q)
    else $error("parity error with parity off");

  assert_read_clears_R12: assert property (@(posedge clk) disable iff (rst)
    ($past(rx_rd) && !$past(rx_done)) |-> !valid_q)
    else $error("read did not clear valid");
endmodule

// File: tb/test_uart_hd_core.sv
module test_uart_hd_core;
  localparam int DIV_W = 16;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [DIV_W-1:0] cfg_div = 16'd1;
  logic [1:0]       cfg_len = 2'd3;
  logic             cfg_par_en = 1'b0, cfg_par_odd = 1'b0, cfg_two_stop = 1'b0;
  logic             cfg_invert = 1'b0, cfg_dir = 1'b1;
  logic             tx_wr = 1'b0;
  logic [7:0]       tx_data = 8'h00;
  logic             tx_busy, tx_line;
  logic             rx_line = 1'b1, rx_rd = 1'b0;
  logic [7:0]       rx_data;
  logic             rx_valid, err_parity, err_frame, err_overrun;

  int checks = 0, bad = 0, cyc = 0;
  bit finished = 0, cmp_on = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  uart_hd_core #(.DIV_W(DIV_W), .OS(16)) i_uart_hd_core (
    .clk(clk), .rst(rst), .cfg_div(cfg_div), .cfg_len(cfg_len),
    .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .cfg_two_stop(cfg_two_stop), .cfg_invert(cfg_invert), .cfg_dir(cfg_dir),
    .tx_wr(tx_wr), .tx_data(tx_data), .tx_busy(tx_busy), .tx_line(tx_line),
    .rx_line(rx_line), .rx_rd(rx_rd), .rx_data(rx_data), .rx_valid(rx_valid),
    .err_parity(err_parity), .err_frame(err_frame), .err_overrun(err_overrun)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int bit_period();
    return 16 * (int'(cfg_div) + 1);
  endfunction

  function automatic int parity_of(input logic [7:0] d, input int nb, input bit odd);
    int ones = 0;
    for (int i = 0; i < nb; i++) ones += d[i];
    return (ones % 2) ^ int'(odd);
  endfunction

  // behavioural transmit model, advanced on every rising edge
  int m_bits[16];
  int m_tot = 0, m_t = 0, m_p = 32;
  bit m_act = 0;
  logic exp_line = 1'b1, exp_busy = 1'b0;

  always @(posedge clk) begin
    if (rst) begin
      m_act = 0;
      m_t = 0;
    end else if (m_act) begin
      m_t++;
      if (m_t == m_tot * m_p) m_act = 0;
    end else if (tx_wr && cfg_dir) begin
      int nb;
      nb = 5 + int'(cfg_len);
      m_tot = 0;
      m_bits[m_tot] = 0; m_tot++;
      for (int i = 0; i < nb; i++) begin m_bits[m_tot] = int'(tx_data[i]); m_tot++; end
      if (cfg_par_en) begin m_bits[m_tot] = parity_of(tx_data, nb, cfg_par_odd); m_tot++; end
      m_bits[m_tot] = 1; m_tot++;
      if (cfg_two_stop) begin m_bits[m_tot] = 1; m_tot++; end
      m_p = bit_period();
      m_t = 0;
      m_act = 1;
    end
    exp_busy = m_act;
    exp_line = logic'(m_act ? m_bits[m_t / m_p] : 1) ^ cfg_invert;
  end

  // compare line and busy against the model on every clock
  always @(negedge clk) begin
    if (cmp_on && !rst) begin
      chk("R2/R3/R5/R6/R7 tx_line", int'(tx_line), int'(exp_line));
      chk("R6 tx_busy", int'(tx_busy), int'(exp_busy));
    end
  end

  // edge at which rx_data last changed
  logic [7:0] last_data = 8'h00;
  int chg_cyc = 0;
  always @(negedge clk) begin
    if (rx_data !== last_data) begin
      last_data = rx_data;
      chg_cyc = cyc;
    end
  end

  task automatic send_tx(input logic [7:0] d, output int busy_cycles);
    tx_wr = 1'b1; tx_data = d;
    @(negedge clk);
    tx_wr = 1'b0;
    busy_cycles = 0;
    while (tx_busy) begin busy_cycles++; @(negedge clk); end
  endtask

  task automatic rx_frame(input logic [7:0] d, input bit bad_par, input bit bad_stop);
    int bits[16];
    int n = 0, nb, p;
    nb = 5 + int'(cfg_len);
    p = bit_period();
    bits[n] = 0; n++;
    for (int i = 0; i < nb; i++) begin bits[n] = int'(d[i]); n++; end
    if (cfg_par_en) begin bits[n] = parity_of(d, nb, cfg_par_odd) ^ int'(bad_par); n++; end
    bits[n] = bad_stop ? 0 : 1; n++;
    if (cfg_two_stop) begin bits[n] = 1; n++; end
    for (int k = 0; k < n; k++) begin
      rx_line = logic'(bits[k]) ^ cfg_invert;
      repeat (p) @(negedge clk);
    end
    rx_line = ~cfg_invert;
    repeat (2 * p) @(negedge clk);
  endtask

  task automatic read_pulse();
    rx_rd = 1'b1;
    @(negedge clk);
    rx_rd = 1'b0;
    @(negedge clk);
  endtask

  task automatic rx_expect(input string tag, input logic [7:0] d, input bit pe, input bit fe);
    logic [7:0] m;
    m = 8'((1 << (5 + int'(cfg_len))) - 1);
    chk({tag, " R4 rx_data"}, int'(rx_data), int'(d & m));
    chk({tag, " R12 rx_valid set"}, int'(rx_valid), 1);
    chk({tag, " R9 err_parity"}, int'(err_parity), int'(pe));
    chk({tag, " R10 err_frame"}, int'(err_frame), int'(fe));
  endtask

  task automatic set_line_cfg(input bit inv);
    cfg_invert = inv;
    rx_line = ~inv;
    repeat (2 * bit_period()) @(negedge clk);
  endtask

  initial begin
    #(4 * 190000);
    if (!finished) begin
      bad++; checks++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    int bc;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R13 reset state
    chk("R13 tx_line idle", int'(tx_line), 1);
    chk("R13 tx_busy", int'(tx_busy), 0);
    chk("R13 rx_valid", int'(rx_valid), 0);
    chk("R13 flags", int'({err_parity, err_frame, err_overrun}), 0);
    cmp_on = 1;

    // transmit: 8 bits, no parity, one stop
    send_tx(8'hA5, bc);
    chk("R2 R6 8N1 busy cycles", bc, 10 * 32);
    // 7 bits even parity
    cfg_len = 2'd2; cfg_par_en = 1'b1; cfg_par_odd = 1'b0;
    send_tx(8'h35, bc);
    chk("R5 7E1 busy cycles", bc, 10 * 32);
    // 5 bits odd parity two stops inverted line
    cfg_len = 2'd0; cfg_par_odd = 1'b1; cfg_two_stop = 1'b1; cfg_invert = 1'b1;
    @(negedge clk);
    send_tx(8'h1B, bc);
    chk("R6 R7 5O2 busy cycles", bc, 9 * 32);
    // 6 bits no parity two stops, second write while busy is dropped
    cfg_len = 2'd1; cfg_par_en = 1'b0; cfg_invert = 1'b0;
    @(negedge clk);
    tx_wr = 1'b1; tx_data = 8'h2C;
    @(negedge clk);
    tx_wr = 1'b0;
    repeat (50) @(negedge clk);
    tx_wr = 1'b1; tx_data = 8'hFF;
    @(negedge clk);
    tx_wr = 1'b0;
    while (tx_busy) @(negedge clk);
    repeat (4) @(negedge clk);
    chk("R1 write while busy dropped", int'(tx_busy), 0);
    // receive direction: write ignored
    cfg_dir = 1'b0;
    @(negedge clk);
    send_tx(8'h55, bc);
    chk("R1 write ignored in receive", bc, 0);

    // receive tests
    cfg_len = 2'd3; cfg_two_stop = 1'b0;
    set_line_cfg(1'b0);
    rx_frame(8'hC3, 0, 0);
    rx_expect("8N1", 8'hC3, 0, 0);
    read_pulse();
    chk("R12 read clears valid", int'(rx_valid), 0);

    cfg_len = 2'd2; cfg_par_en = 1'b1; cfg_par_odd = 1'b0;
    rx_frame(8'h7A, 0, 0);
    rx_expect("7E1 good", 8'h7A, 0, 0);
    read_pulse();
    rx_frame(8'h4D, 1, 0);
    rx_expect("7E1 bad parity", 8'h4D, 1, 0);
    read_pulse();

    cfg_len = 2'd0; cfg_par_odd = 1'b1; cfg_two_stop = 1'b1;
    set_line_cfg(1'b1);
    rx_frame(8'hF5, 0, 0);
    rx_expect("5O2 inverted", 8'hF5, 0, 0);
    read_pulse();

    cfg_len = 2'd3; cfg_par_en = 1'b0; cfg_two_stop = 1'b0;
    set_line_cfg(1'b0);
    rx_frame(8'h96, 0, 1);
    rx_expect("bad stop", 8'h96, 0, 1);
    read_pulse();

    // R8 short low pulse rejected
    rx_line = 1'b0;
    repeat (bit_period() / 4) @(negedge clk);
    rx_line = 1'b1;
    repeat (2 * bit_period()) @(negedge clk);
    chk("R8 glitch ignored", int'(rx_valid), 0);
    rx_frame(8'h3C, 0, 0);
    rx_expect("R8 after glitch", 8'h3C, 0, 0);
    read_pulse();

    // R1 receive ignored in transmit direction
    cfg_dir = 1'b1;
    @(negedge clk);
    rx_frame(8'h81, 0, 0);
    chk("R1 receive ignored while sending direction", int'(rx_valid), 0);
    cfg_dir = 1'b0;
    repeat (4) @(negedge clk);

    // R11 overrun
    rx_frame(8'h11, 0, 0);
    rx_frame(8'h22, 0, 0);
    chk("R11 overrun set", int'(err_overrun), 1);
    chk("R11 newest data kept", int'(rx_data), 8'h22);
    read_pulse();

    // read strobe swept around the completion edge
    for (int off = -2; off <= 2; off++) begin
      int c0, e_rd, e_done;
      bit late;
      rx_frame(8'h40 + 8'(off + 2), 0, 0);
      c0 = cyc;
      e_rd = c0 + 1 + 2 + 8 * 2 + 16 * 2 * 9 + off;
      fork
        rx_frame(8'h90 + 8'(off + 2), 0, 0);
        begin
          while (cyc < e_rd - 1) @(negedge clk);
          rx_rd = 1'b1;
          @(negedge clk);
          rx_rd = 1'b0;
        end
      join
      e_done = chg_cyc;
      late = (e_rd > e_done);
      chk("R11 sweep overrun", int'(err_overrun), int'(late));
      chk("R12 sweep valid", int'(rx_valid), int'(!late));
      chk("R4 sweep data", int'(rx_data), int'(8'h90 + 8'(off + 2)));
      if (!late) read_pulse();
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule